// File: doc/BRIEF.md
# Two-Channel Second-Order Delta-Sigma Modulator

This block turns two streams of oversampled signed PCM samples into two 1-bit streams for an audio DAC. Each channel has its own loop of two cascaded integrators and a sign quantizer. The output bit is fed back as plus or minus full scale, which gives a noise transfer function of (1 - z^-1)^2 and a signal path of one tick of delay. The block is clocked by the system clock. A single enable marks each modulator tick, at 192 times the audio sample rate. Both channels advance on the same enable, so their bitstreams stay aligned.

An upstream interpolator holds each sample steady between ticks. The reconstruction filter downstream averages the bitstream back to an analog level. Both integrators saturate rather than wrap. After an overload the loop therefore settles back instead of ringing between rails. Inputs up to 70 % of full scale are the intended operating range.

Top module: `dsm2_stereo`

## Requirements
- R1: While reset is high on a clock edge, both integrators of both channels clear to zero and both output bits become 0. The output bits stay 0 until the first enabled tick.
- R2: On a clock edge where the enable is low, the output bits and all integrator state keep their values, whatever the inputs do.
- R3: For a constant input x (16-bit two's complement, full scale 32768), the fraction of 1s over any 1024 consecutive ticks after settling equals (1 + x/32768)/2 within 1 % of full scale. This holds for |x| up to 0.7 of full scale.
- R4: The two channels update on the same tick, each from its own input. Equal inputs from reset give identical bitstreams, and unequal inputs give independent averages.
- R5: After reset with a zero input, the first four enabled ticks give the bits 1, 1, 0, 1. The quantizer emits 1 when the second integrator is zero or positive. The fed-back value is +32768 for a 1 and -32768 for a 0.
- R6: The integrators are 22 bits wide and clamp at their limits. A sustained input of -32768 drives the loop into clamp, and the output then stays 0 without any wrap-around burst of 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator tick enable, shared by both channels |
| pcm_l | input | 16 | Left oversampled sample, signed |
| pcm_r | input | 16 | Right oversampled sample, signed |
| bit_l | output | 1 | Left 1-bit stream |
| bit_r | output | 1 | Right 1-bit stream |

## Verification
The hardest state to reach from the ports is the clamped integrator. No in-range signal gets there. The loop only runs away when the input sits at the negative full-scale code. At that code an output of 0 feeds back nothing into the first integrator, while an output of 1 kicks it by twice full scale. The bench holds that code for several thousand ticks. It then counts the 1s in a late window, where a wrapping accumulator would show bursts. The DC tests run with gaps in the enable, so the same sequence also exercises the hold behaviour.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int IN_W  = 16;
    localparam int ACC_W = 22;
    localparam int NCH   = 2;
    localparam int FS_I  = 2 ** (IN_W - 1);

    typedef logic signed [IN_W-1:0]  sample_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam acc_t FS_POS  = acc_t'(FS_I);
    localparam acc_t FS_NEG  = -acc_t'(FS_I);

    function automatic acc_t sat_add(input acc_t a, input acc_t b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? ACC_MIN : ACC_MAX;
        return s[ACC_W-1:0];
    endfunction

    function automatic acc_t widen(input sample_t x);
        return acc_t'(x);
    endfunction
endpackage

// File: rtl/dsm_integ.sv
module dsm_integ
    import dsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  acc_t inc,
    output acc_t acc,
    output acc_t acc_nxt
);
    assign acc_nxt = sat_add(acc, inc);

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= acc_nxt;
    end

    // R6: two non-negative terms never produce a negative sum
    p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !acc[ACC_W-1] && !inc[ACC_W-1]) |=> !acc[ACC_W-1]);
    // R6: two negative terms never produce a non-negative sum
    p_no_wrap_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (en && acc[ACC_W-1] && inc[ACC_W-1]) |=> acc[ACC_W-1]);
    // R2: state frozen without enable
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));
    // R1: reset clears the accumulator
    p_clear_r1: assert property (@(posedge clk) rst |=> acc == '0);
endmodule

// File: rtl/dsm_channel.sv
module dsm_channel
    import dsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t x,
    output logic    bit_o
);
    acc_t fb_neg;
    acc_t inc1, inc2;
    acc_t i1, i1_nxt, i2, i2_nxt;

    // subtracting the fed-back level: -(+FS) for a 1, -(-FS) for a 0
    assign fb_neg = bit_o ? FS_NEG : FS_POS;
    assign inc1   = sat_add(widen(x), fb_neg);
    assign inc2   = sat_add(i1_nxt, fb_neg);

    dsm_integ u_int1 (
        .clk(clk), .rst(rst), .en(en),
        .inc(inc1), .acc(i1), .acc_nxt(i1_nxt)
    );

    dsm_integ u_int2 (
        .clk(clk), .rst(rst), .en(en),
        .inc(inc2), .acc(i2), .acc_nxt(i2_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bit_o <= 1'b0;
        else if (en)
            bit_o <= ~i2_nxt[ACC_W-1];
    end

    // R1: output is 0 right after reset
    p_reset_bit_r1: assert property (@(posedge clk) rst |=> !bit_o);
    // R2: output holds without enable
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(bit_o));
    // R5: registered bit agrees with the sign of the stored second integrator
    p_sign_match_r5: assert property (@(posedge clk) disable iff (rst)
        en |=> bit_o == !i2[ACC_W-1]);
endmodule

// File: rtl/dsm2_stereo.sv
module dsm2_stereo
    import dsm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W-1:0] pcm_l,
    input  logic signed [IN_W-1:0] pcm_r,
    output logic                   bit_l,
    output logic                   bit_r
);
    sample_t xin  [NCH];
    logic    bits [NCH];

    assign xin[0] = pcm_l;
    assign xin[1] = pcm_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsm_channel u_ch (
            .clk(clk), .rst(rst), .en(en),
            .x(xin[c]), .bit_o(bits[c])
        );
    end

    assign bit_l = bits[0];
    assign bit_r = bits[1];

    // R4: both channels advance on the shared tick; with no tick neither moves
    p_joint_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bit_l) && $stable(bit_r)));
endmodule

// File: tb/tb_dsm2_stereo.sv
module tb_dsm2_stereo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [15:0] pcm_l = '0;
    logic signed [15:0] pcm_r = '0;
    logic bit_l, bit_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dsm2_stereo dut (
        .clk(clk), .rst(rst), .en(en),
        .pcm_l(pcm_l), .pcm_r(pcm_r),
        .bit_l(bit_l), .bit_r(bit_r)
    );

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic do_reset();
        en  = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick();
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        en = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset state and no movement before the first tick
    task automatic t_reset();
        pcm_l = 16'sd12000; pcm_r = -16'sd9000;
        do_reset();
        chk(bit_l == 0 && bit_r == 0, "R1 reset", bit_l + bit_r, 0);
        repeat (10) idle();
        chk(bit_l == 0 && bit_r == 0, "R1 idle after reset", bit_l + bit_r, 0);
    endtask

    // R5: fixed start-up sequence for zero input
    task automatic t_start();
        logic exp_seq [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
        pcm_l = '0; pcm_r = '0;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(bit_l == exp_seq[k], "R5 start left", bit_l, exp_seq[k]);
            chk(bit_r == exp_seq[k], "R5 start right", bit_r, exp_seq[k]);
        end
    endtask

    // R2: outputs frozen while enable is low, even with changing inputs
    task automatic t_hold();
        logic hl, hr;
        int bad = 0;
        pcm_l = 16'sd3000; pcm_r = -16'sd7000;
        do_reset();
        repeat (37) tick();
        hl = bit_l; hr = bit_r;
        for (int k = 0; k < 20; k++) begin
            pcm_l = 16'(k * 1500);
            pcm_r = -16'(k * 1300);
            idle();
            if (bit_l != hl || bit_r != hr) bad++;
        end
        chk(bad == 0, "R2 hold", bad, 0);
    endtask

    // R3/R4: DC average tracking, optionally with gaps in the enable
    task automatic t_dc(input int xl, input int xr, input bit gapped);
        int ones_l = 0, ones_r = 0;
        real el, er;
        pcm_l = 16'(xl); pcm_r = 16'(xr);
        do_reset();
        for (int k = 0; k < 256; k++) begin
            tick();
            if (gapped) idle();
        end
        for (int k = 0; k < 1024; k++) begin
            tick();
            ones_l += int'(bit_l);
            ones_r += int'(bit_r);
            if (gapped && (k % 3 == 0)) idle();
        end
        el = 512.0 + real'(xl) / 64.0;
        er = 512.0 + real'(xr) / 64.0;
        chk((ones_l - el) <= 5.12 && (el - ones_l) <= 5.12, "R3 dc left", ones_l, el);
        chk((ones_r - er) <= 5.12 && (er - ones_r) <= 5.12, "R4 dc right", ones_r, er);
    endtask

    // R4: identical inputs give identical streams
    task automatic t_same();
        int diff = 0;
        pcm_l = 16'sd5000; pcm_r = 16'sd5000;
        do_reset();
        for (int k = 0; k < 600; k++) begin
            tick();
            if (bit_l != bit_r) diff++;
        end
        chk(diff == 0, "R4 matched channels", diff, 0);
    endtask

    // R6: negative full-scale overload clamps and never wraps
    task automatic t_sat();
        int ones = 0;
        pcm_l = -16'sd32768; pcm_r = -16'sd32768;
        do_reset();
        repeat (3000) tick();
        for (int k = 0; k < 1024; k++) begin
            tick();
            ones += int'(bit_l) + int'(bit_r);
        end
        chk(ones == 0, "R6 clamp no wrap", ones, 0);
        pcm_l = '0; pcm_r = '0;
        do_reset();
        chk(bit_l == 0 && bit_r == 0, "R1 reset after overload", bit_l + bit_r, 0);
        tick();
        chk(bit_l == 1 && bit_r == 1, "R5 first tick after overload", bit_l + bit_r, 2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_start();
        t_hold();
        t_dc(0, 0, 1'b0);
        t_dc(16384, -16384, 1'b0);
        t_dc(22937, -22937, 1'b1);
        t_dc(-8000, 3000, 1'b1);
        t_dc(1000, -21000, 1'b0);
        t_same();
        t_sat();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule